// File: doc/BRIEF.md
# Debug Register Access Permission Gate

This block stands between three requesters and a debug register file and decides, for each read or write, whether it may reach the registers. The three requesters are the processor's coprocessor-style port, a memory-mapped slave port, and an external debugger port. Each request is checked against three tests, and all three must pass. The privilege test depends on the requester. The lock test uses a lock bit for the region being addressed. The power test applies to regions that live in the core power domain and passes only while that domain is powered up.

A granted access is forwarded to the register file in the same cycle through a single shared strobe set. A refused one never reaches it. Each port gets a one-cycle registered ready together with its own error form: an undefined-instruction flag on the coprocessor port, a slave error on the memory-mapped port, and an error flag on the debugger port. On the memory-mapped port a refused access is either aborted or silently ignored, chosen by a parameter.

A small control register inside the block holds a user-disable bit. While that bit is clear, unprivileged code may reach a low baseline window of the register map. Once privileged code sets it, every register needs privilege.

Top module: `dbg_perm_gate`

## Requirements
- R1: An access is granted only when the privilege, lock and power tests all pass. The ready pulse carries an error exactly when the access was refused.
- R2: Regions whose bit is set in CORE_RGN_MASK are refused while core_pwr_up is 0. Other regions are unaffected by core_pwr_up.
- R3: The region index is the top RGN_BITS bits of the address. Any access to a region whose lock_vec bit is 1 is refused.
- R4: An unprivileged access is allowed only to addresses below BASE_CNT, and only while the user-disable bit is 0. The debugger port always counts as privileged.
- R5: Address CTL_ADDR is the block's control register. Bit 0 is the user-disable bit, which resets to 0. A granted write to CTL_ADDR loads wdata[0] into it. A granted read of CTL_ADDR returns it in bit 0 with all other bits zero. The register file is not strobed for this address.
- R6: A refused write leaves the register file and the control bit unchanged, and rf_we stays low. A refused read returns all-zero data.
- R7: The refusal indication is cp_undef on the coprocessor port and ext_err on the debugger port. On the memory-mapped port it is mm_slverr when MM_ABORT is 1. When MM_ABORT is 0, mm_slverr stays low and the refused access is dropped.
- R8: warm_hold has no effect on decisions for the memory-mapped or debugger ports. While warm_hold is 1, coprocessor requests are refused.
- R9: At most one request is accepted per cycle, with fixed priority: debugger first, then memory-mapped, then coprocessor. A request that loses waits with its request held.
- R10: The ready output is a single-cycle pulse in the cycle after acceptance, and the response data is valid with it. A port is not accepted again while its ready is high. After reset, all ready and error outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| core_pwr_up | input | 1 | Core power domain is powered up |
| warm_hold | input | 1 | Processor held in warm reset |
| lock_vec | input | 2**RGN_BITS | Lock bit per region |
| cp_req | input | 1 | Coprocessor port request |
| cp_wr | input | 1 | Coprocessor write (1) or read (0) |
| cp_priv | input | 1 | Coprocessor requester is privileged |
| cp_addr | input | AW | Coprocessor register address |
| cp_wdata | input | DW | Coprocessor write data |
| cp_ready | output | 1 | Coprocessor response pulse |
| cp_undef | output | 1 | Undefined-instruction indication |
| cp_rdata | output | DW | Coprocessor read data |
| mm_req | input | 1 | Memory-mapped request |
| mm_wr | input | 1 | Memory-mapped write |
| mm_priv | input | 1 | Memory-mapped requester is privileged |
| mm_addr | input | AW | Memory-mapped address |
| mm_wdata | input | DW | Memory-mapped write data |
| mm_ready | output | 1 | Memory-mapped response pulse |
| mm_slverr | output | 1 | Slave error response |
| mm_rdata | output | DW | Memory-mapped read data |
| ext_req | input | 1 | Debugger request |
| ext_wr | input | 1 | Debugger write |
| ext_addr | input | AW | Debugger address |
| ext_wdata | input | DW | Debugger write data |
| ext_ready | output | 1 | Debugger response pulse |
| ext_err | output | 1 | Debugger error indication |
| ext_rdata | output | DW | Debugger read data |
| rf_we | output | 1 | Register file write strobe |
| rf_re | output | 1 | Register file read strobe |
| rf_addr | output | AW | Register file address |
| rf_wdata | output | DW | Register file write data |
| rf_rdata | input | DW | Register file read data (combinational) |

## Verification
The bench builds the block with a 6-bit address, two region bits (four regions of 16 registers), the upper two regions in the core domain, a baseline window of 4, the control register at address 8, and MM_ABORT set to 1. With such a small map, random addresses land often on locked regions, on powered-down regions, on the baseline window and on the control register. The user-disable bit therefore toggles many times during the random phase, and its interaction with unprivileged baseline reads is exercised again and again. Directed cases cover simultaneous requests, the warm-hold asymmetry between ports, and refused writes followed by readback.

// File: rtl/dbg_perm_gate.sv
module dbg_perm_gate #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int RGN_BITS = 2,
  parameter logic [(1<<RGN_BITS)-1:0] CORE_RGN_MASK = '1,
  parameter int BASE_CNT = 4,
  parameter int CTL_ADDR = 8,
  parameter bit MM_ABORT = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     core_pwr_up,
  input  logic                     warm_hold,
  input  logic [(1<<RGN_BITS)-1:0] lock_vec,
  input  logic                     cp_req,
  input  logic                     cp_wr,
  input  logic                     cp_priv,
  input  logic [AW-1:0]            cp_addr,
  input  logic [DW-1:0]            cp_wdata,
  output logic                     cp_ready,
  output logic                     cp_undef,
  output logic [DW-1:0]            cp_rdata,
  input  logic                     mm_req,
  input  logic                     mm_wr,
  input  logic                     mm_priv,
  input  logic [AW-1:0]            mm_addr,
  input  logic [DW-1:0]            mm_wdata,
  output logic                     mm_ready,
  output logic                     mm_slverr,
  output logic [DW-1:0]            mm_rdata,
  input  logic                     ext_req,
  input  logic                     ext_wr,
  input  logic [AW-1:0]            ext_addr,
  input  logic [DW-1:0]            ext_wdata,
  output logic                     ext_ready,
  output logic                     ext_err,
  output logic [DW-1:0]            ext_rdata,
  output logic                     rf_we,
  output logic                     rf_re,
  output logic [AW-1:0]            rf_addr,
  output logic [DW-1:0]            rf_wdata,
  input  logic [DW-1:0]            rf_rdata
);

  localparam logic [AW-1:0] CTL_A  = AW'(CTL_ADDR);
  localparam logic [AW-1:0] BASE_A = AW'(BASE_CNT);

  logic                usr_dis;
  logic [DW-1:0]       rdata_q;
  logic                ext_go, mm_go, cp_go, any_go;
  logic                s_wr, s_priv;
  logic [AW-1:0]       s_addr;
  logic [DW-1:0]       s_wdata;
  logic [RGN_BITS-1:0] rgn;
  logic                priv_ok, pwr_ok, lock_ok, hold_ok, grant, is_ctl;
  logic [DW-1:0]       rd_val;

  // fixed priority: debugger, memory-mapped, coprocessor
  assign ext_go = ext_req & ~ext_ready;
  assign mm_go  = mm_req & ~mm_ready & ~ext_go;
  assign cp_go  = cp_req & ~cp_ready & ~ext_go & ~mm_go;
  assign any_go = ext_go | mm_go | cp_go;

  always_comb begin
    s_wr = cp_wr; s_priv = cp_priv; s_addr = cp_addr; s_wdata = cp_wdata;
    if (ext_go) begin
      s_wr = ext_wr; s_priv = 1'b1; s_addr = ext_addr; s_wdata = ext_wdata;
    end else if (mm_go) begin
      s_wr = mm_wr; s_priv = mm_priv; s_addr = mm_addr; s_wdata = mm_wdata;
    end
  end

  assign rgn     = s_addr[AW-1 -: RGN_BITS];
  assign priv_ok = s_priv | ((s_addr < BASE_A) & ~usr_dis);
  assign pwr_ok  = ~CORE_RGN_MASK[rgn] | core_pwr_up;
  assign lock_ok = ~lock_vec[rgn];
  assign hold_ok = ~(cp_go & warm_hold);
  assign grant   = any_go & priv_ok & pwr_ok & lock_ok & hold_ok;
  assign is_ctl  = (s_addr == CTL_A);

  assign rf_we    = grant & s_wr & ~is_ctl;
  assign rf_re    = grant & ~s_wr & ~is_ctl;
  assign rf_addr  = s_addr;
  assign rf_wdata = s_wdata;
  assign rd_val   = is_ctl ? {{(DW-1){1'b0}}, usr_dis} : rf_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_ready  <= 1'b0;
      mm_ready  <= 1'b0;
      ext_ready <= 1'b0;
      cp_undef  <= 1'b0;
      mm_slverr <= 1'b0;
      ext_err   <= 1'b0;
      rdata_q   <= '0;
      usr_dis   <= 1'b0;
    end else begin
      cp_ready  <= cp_go;
      mm_ready  <= mm_go;
      ext_ready <= ext_go;
      cp_undef  <= cp_go & ~grant;
      mm_slverr <= mm_go & ~grant & MM_ABORT;
      ext_err   <= ext_go & ~grant;
      rdata_q   <= (grant & ~s_wr) ? rd_val : '0;
      if (grant & s_wr & is_ctl) usr_dis <= s_wdata[0];
    end
  end

  assign cp_rdata  = cp_ready  ? rdata_q : '0;
  assign mm_rdata  = mm_ready  ? rdata_q : '0;
  assign ext_rdata = ext_ready ? rdata_q : '0;

  // R9
  one_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cp_ready, mm_ready, ext_ready}));

  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ready |=> !ext_ready);

  // R3
  lock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we | rf_re) |-> !lock_vec[rf_addr[AW-1 -: RGN_BITS]]);

  // R2
  pwr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rf_we | rf_re) && !core_pwr_up) |-> !CORE_RGN_MASK[rf_addr[AW-1 -: RGN_BITS]]);

  // R7
  err_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_undef |-> cp_ready) and (mm_slverr |-> mm_ready) and (ext_err |-> ext_ready));

  // R6
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_err |-> ext_rdata == '0) and (cp_undef |-> cp_rdata == '0));

  // R8
  hold_cp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_ready && $past(warm_hold)) |-> cp_undef);

endmodule

// File: tb/dbg_perm_gate_tb.sv
module dbg_perm_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam logic [3:0] CORE = 4'b1100;
  localparam int BASE = 4;
  localparam int CTL = 8;

  logic clk = 0, rst_n = 0;
  logic core_pwr_up = 1, warm_hold = 0;
  logic [3:0] lock_vec = 0;
  logic cp_req = 0, cp_wr = 0, cp_priv = 0; logic [AW-1:0] cp_addr = 0; logic [DW-1:0] cp_wdata = 0;
  logic mm_req = 0, mm_wr = 0, mm_priv = 0; logic [AW-1:0] mm_addr = 0; logic [DW-1:0] mm_wdata = 0;
  logic ext_req = 0, ext_wr = 0; logic [AW-1:0] ext_addr = 0; logic [DW-1:0] ext_wdata = 0;
  logic cp_ready, cp_undef, mm_ready, mm_slverr, ext_ready, ext_err;
  logic [DW-1:0] cp_rdata, mm_rdata, ext_rdata;
  logic rf_we, rf_re; logic [AW-1:0] rf_addr; logic [DW-1:0] rf_wdata, rf_rdata;

  logic [DW-1:0] mem [64];
  logic [DW-1:0] emem [64];
  logic eusr = 0;
  int vectors = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rf_rdata = mem[rf_addr];
  always @(posedge clk) if (rf_we) mem[rf_addr] <= rf_wdata;

  dbg_perm_gate #(.AW(AW), .DW(DW), .RGN_BITS(2), .CORE_RGN_MASK(CORE),
                  .BASE_CNT(BASE), .CTL_ADDR(CTL), .MM_ABORT(1'b1)) u_dut (
    .clk, .rst_n, .core_pwr_up, .warm_hold, .lock_vec,
    .cp_req, .cp_wr, .cp_priv, .cp_addr, .cp_wdata, .cp_ready, .cp_undef, .cp_rdata,
    .mm_req, .mm_wr, .mm_priv, .mm_addr, .mm_wdata, .mm_ready, .mm_slverr, .mm_rdata,
    .ext_req, .ext_wr, .ext_addr, .ext_wdata, .ext_ready, .ext_err, .ext_rdata,
    .rf_we, .rf_re, .rf_addr, .rf_wdata, .rf_rdata);

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit exp_ok(input int port, input bit priv, input logic [AW-1:0] a);
    bit ok = 1;
    logic [1:0] rg = a[AW-1 -: 2];
    if (lock_vec[rg]) ok = 0;
    if (CORE[rg] && !core_pwr_up) ok = 0;
    if (!(port == 2 || priv || (a < BASE && !eusr))) ok = 0;
    if (port == 0 && warm_hold) ok = 0;
    return ok;
  endfunction

  task automatic acc(input int port, input bit wr, input bit priv, input logic [AW-1:0] a,
                     input logic [DW-1:0] wd, input string tag);
    bit rdy, err, ok;
    logic [DW-1:0] rd, erd;
    int waits = 0;
    @(negedge clk);
    case (port)
      0: begin cp_req = 1; cp_wr = wr; cp_priv = priv; cp_addr = a; cp_wdata = wd; end
      1: begin mm_req = 1; mm_wr = wr; mm_priv = priv; mm_addr = a; mm_wdata = wd; end
      default: begin ext_req = 1; ext_wr = wr; ext_addr = a; ext_wdata = wd; end
    endcase
    do begin
      @(negedge clk);
      waits++;
      case (port)
        0: begin rdy = cp_ready; err = cp_undef; rd = cp_rdata; end
        1: begin rdy = mm_ready; err = mm_slverr; rd = mm_rdata; end
        default: begin rdy = ext_ready; err = ext_err; rd = ext_rdata; end
      endcase
    end while (!rdy && waits < 20);
    cp_req = 0; mm_req = 0; ext_req = 0;
    chk(rdy, {tag, " R10 ready"}, DW'(rdy), 1);
    ok = exp_ok(port, priv, a);
    erd = (!wr && ok) ? ((a == CTL) ? DW'(eusr) : emem[a]) : '0;
    if (ok && wr) begin
      if (a == CTL) eusr = wd[0];
      else emem[a] = wd;
    end
    chk(err == !ok, {tag, " R1 err"}, DW'(err), DW'(!ok));
    chk(rd == erd, {tag, " R6 rdata"}, rd, erd);
    chk(mem[a] == emem[a], {tag, " R6 regfile"}, mem[a], emem[a]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 64; i++) begin mem[i] = 32'hA000_0000 + i * 7; emem[i] = mem[i]; end
    repeat (3) @(negedge clk);
    chk(!cp_ready && !mm_ready && !ext_ready && !cp_undef && !mm_slverr && !ext_err,
        "R10 reset outputs", {cp_ready, mm_ready, ext_ready}, 0);
    rst_n = 1;

    acc(0, 0, 1, CTL, 0, "R5 ctl reset read");
    acc(0, 0, 0, 2, 0, "R4 unpriv baseline read");
    acc(1, 0, 0, 20, 0, "R4 unpriv outside baseline");
    acc(2, 0, 0, 20, 0, "R4 debugger always privileged");
    acc(0, 1, 0, CTL, 1, "R4 unpriv ctl write");
    acc(0, 1, 1, CTL, 32'hFFFF_FFFF, "R5 ctl set");
    acc(1, 0, 1, CTL, 0, "R5 ctl readback");
    acc(0, 0, 0, 2, 0, "R4 user disabled");
    acc(2, 1, 0, CTL, 0, "R5 ctl clear");
    acc(0, 0, 0, 1, 0, "R4 user reenabled");

    lock_vec = 4'b0010;
    acc(2, 1, 0, 6'h12, 32'hDEAD, "R3 locked write");
    acc(1, 0, 1, 6'h12, 0, "R3 locked read");
    lock_vec = 0;
    acc(2, 0, 0, 6'h12, 0, "R6 unchanged after refused write");

    core_pwr_up = 0;
    acc(1, 0, 1, 6'h25, 0, "R2 powered down core region");
    acc(1, 1, 1, 6'h35, 32'h55, "R2 powered down write");
    acc(1, 0, 1, 6'h15, 0, "R2 non-core region");
    core_pwr_up = 1;
    acc(1, 0, 1, 6'h25, 0, "R2 powered up");

    warm_hold = 1;
    acc(1, 1, 1, 6'h21, 32'h77, "R8 mm during hold");
    acc(2, 0, 0, 6'h21, 0, "R8 ext during hold");
    acc(0, 0, 1, 6'h21, 0, "R8 cp during hold");
    acc(1, 0, 0, 6'h01, 0, "R7 mm slverr unpriv ok base");
    warm_hold = 0;
    acc(1, 0, 0, 6'h30, 0, "R7 mm slverr");

    @(negedge clk);
    cp_req = 1; cp_wr = 0; cp_priv = 1; cp_addr = 3;
    ext_req = 1; ext_wr = 0; ext_addr = 5;
    @(negedge clk);
    chk(ext_ready && !cp_ready, "R9 debugger wins", {ext_ready, cp_ready}, 2'b10);
    chk(ext_rdata == emem[5], "R9 winner data", ext_rdata, emem[5]);
    ext_req = 0;
    @(negedge clk);
    chk(!ext_ready && cp_ready, "R10 pulse then loser served", {ext_ready, cp_ready}, 2'b01);
    chk(cp_rdata == emem[3], "R9 loser data", cp_rdata, emem[3]);
    cp_req = 0;
    @(negedge clk);
    chk(!cp_ready, "R10 single pulse", DW'(cp_ready), 0);

    for (int n = 0; n < 1500; n++) begin
      int port;
      logic [AW-1:0] a;
      if (n % 8 == 0) begin
        lock_vec = 4'($urandom & $urandom & $urandom);
        core_pwr_up = ($urandom % 4) != 0;
        warm_hold = ($urandom % 5) == 0;
      end
      port = $urandom % 3;
      a = ($urandom % 6 == 0) ? AW'(CTL) : AW'($urandom);
      acc(port, $urandom % 2, ($urandom % 4) != 0, a, $urandom, "R1 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule